// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. It walks one instruction at a time through a chain of states and drives the datapath's write strobes and multiplexer selects in each state. The datapath itself is outside this block: the register file, the ALU, the memory, the instruction register, the A/B operand latches, the ALU result latch and the memory data latch. The block reads only the opcode and function fields of the latched instruction and the ALU zero flag.

Every instruction starts with a shared pair of states, fetch and then decode. During decode the ALU adds the PC to the scaled immediate, so the branch target is already latched when a branch reaches its compare state. The per-class tail is one state for an equality branch, two for a register-type operation, two for a store and three for a load. After that the sequencer goes back to fetch. The PC write in the branch compare state follows the zero flag in the same cycle, so that strobe is a Mealy output.

Top module: `mc_seq_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces the fetch state. While reset is low the outputs show the fetch vector.
- R2: Fetch asserts pc_we and ir_we, with alu_a_sel=0 (PC), alu_b_sel=01 (constant 4), alu_op=000 (add), mem_addr_sel=0 (PC) and pc_src_sel=0 (live ALU result). All other outputs are 0.
- R3: Decode asserts no write strobe and drives alu_a_sel=0, alu_b_sel=11 (immediate shifted left by 2) and alu_op=000. All other outputs are 0.
- R4: Branch-equal (opcode 000100) runs one compare state with alu_a_sel=1 (A), alu_b_sel=00 (B), alu_op=001 (subtract) and pc_src_sel=1 (latched ALU result). pc_we equals alu_zero in that same cycle.
- R5: Register-type (opcode 000000) runs an execute state with A and B as operands. alu_op follows the function field: 100000→000, 100010→001, 100100→010, 100101→011, 100111→100, 101010→101, and any other code→000. The next state asserts rf_we with reg_dst_sel=1 (Rd) and rf_wdata_sel=0 (ALU result latch).
- R6: Store (opcode 101011) runs an address state (alu_a_sel=1, alu_b_sel=10 sign-extended immediate, add). It then runs a state that asserts mem_we with mem_addr_sel=1 (ALU result latch).
- R7: Load (opcode 100011) runs the same address state, then a read state with mem_addr_sel=1 and no strobe. A final state then asserts rf_we with reg_dst_sel=0 (Rt) and rf_wdata_sel=1 (memory data latch).
- R8: Counted from fetch to the next fetch, branch takes 3 cycles, register-type and store take 4, and load takes 5.
- R9: Any other opcode goes from decode straight back to fetch and asserts no write strobe after fetch.
- R10: In every state, each select that the state does not use is driven to 0. At most one of mem_we, rf_we and ir_we is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the latched instruction |
| funct | input | 6 | Function field of the latched instruction |
| alu_zero | input | 1 | ALU zero flag |
| pc_we | output | 1 | PC write strobe |
| mem_we | output | 1 | Memory write strobe |
| rf_we | output | 1 | Register file write strobe |
| ir_we | output | 1 | Instruction register write strobe |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 four, 10 sign-extended imm, 11 imm shifted by 2 |
| alu_op | output | 3 | ALU operation code |
| reg_dst_sel | output | 1 | Write register: 0 Rt, 1 Rd |
| rf_wdata_sel | output | 1 | Write data: 0 ALU result latch, 1 memory data latch |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result latch |
| pc_src_sel | output | 1 | Next PC: 0 live ALU result, 1 ALU result latch |

## Verification
The hardest case to reach is the branch compare state. There pc_we depends on the zero flag in the same cycle rather than on the state alone, so a registered-output mistake or a missing zero gate only shows when zero is toggled exactly in that cycle. The stimulus drives alu_zero both high and low on separate branches, and it also drives zero high during non-branch states to show that zero has no effect there. A reset pulled in the middle of a load checks that the sequence is abandoned and fetch resumes.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;
  localparam int OP_W    = 6;
  localparam int ALUOP_W = 3;
  localparam int BSEL_W  = 2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_BR_CMP, ST_R_EXE, ST_R_WB,
    ST_SW_ADDR, ST_SW_MEM, ST_LW_ADDR, ST_LW_MEM, ST_LW_WB
  } seq_state_e;

  typedef enum logic [2:0] {
    CLS_RTYPE, CLS_LOAD, CLS_STORE, CLS_BEQ, CLS_OTHER
  } instr_cls_e;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

  localparam logic [ALUOP_W-1:0] AOP_ADD = 3'd0;
  localparam logic [ALUOP_W-1:0] AOP_SUB = 3'd1;
  localparam logic [ALUOP_W-1:0] AOP_AND = 3'd2;
  localparam logic [ALUOP_W-1:0] AOP_OR  = 3'd3;
  localparam logic [ALUOP_W-1:0] AOP_NOR = 3'd4;
  localparam logic [ALUOP_W-1:0] AOP_SLT = 3'd5;

  localparam logic [BSEL_W-1:0] BSEL_REG  = 2'd0;
  localparam logic [BSEL_W-1:0] BSEL_FOUR = 2'd1;
  localparam logic [BSEL_W-1:0] BSEL_IMM  = 2'd2;
  localparam logic [BSEL_W-1:0] BSEL_IMM4 = 2'd3;

  function automatic instr_cls_e classify(input logic [OP_W-1:0] op);
    case (op)
      OPC_RTYPE: return CLS_RTYPE;
      OPC_LOAD:  return CLS_LOAD;
      OPC_STORE: return CLS_STORE;
      OPC_BEQ:   return CLS_BEQ;
      default:   return CLS_OTHER;
    endcase
  endfunction

  function automatic logic [ALUOP_W-1:0] funct_to_aluop(input logic [5:0] fn);
    case (fn)
      6'b100000: return AOP_ADD;
      6'b100010: return AOP_SUB;
      6'b100100: return AOP_AND;
      6'b100101: return AOP_OR;
      6'b100111: return AOP_NOR;
      6'b101010: return AOP_SLT;
      default:   return AOP_ADD;
    endcase
  endfunction
endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
  import mc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  instr_cls_e cls,
  output seq_state_e state_q
);
  seq_state_e state_d;

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:   state_d = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CLS_RTYPE: state_d = ST_R_EXE;
          CLS_LOAD:  state_d = ST_LW_ADDR;
          CLS_STORE: state_d = ST_SW_ADDR;
          CLS_BEQ:   state_d = ST_BR_CMP;
          default:   state_d = ST_FETCH;
        endcase
      end
      ST_R_EXE:   state_d = ST_R_WB;
      ST_SW_ADDR: state_d = ST_SW_MEM;
      ST_LW_ADDR: state_d = ST_LW_MEM;
      ST_LW_MEM:  state_d = ST_LW_WB;
      default:    state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/mc_seq_out.sv
module mc_seq_out
  import mc_seq_pkg::*;
(
  input  seq_state_e          state_q,
  input  logic [5:0]          funct,
  input  logic                alu_zero,
  output logic                pc_we,
  output logic                mem_we,
  output logic                rf_we,
  output logic                ir_we,
  output logic                alu_a_sel,
  output logic [BSEL_W-1:0]   alu_b_sel,
  output logic [ALUOP_W-1:0]  alu_op,
  output logic                reg_dst_sel,
  output logic                rf_wdata_sel,
  output logic                mem_addr_sel,
  output logic                pc_src_sel
);
  always_comb begin
    pc_we = 1'b0; mem_we = 1'b0; rf_we = 1'b0; ir_we = 1'b0;
    alu_a_sel = 1'b0; alu_b_sel = BSEL_REG; alu_op = AOP_ADD;
    reg_dst_sel = 1'b0; rf_wdata_sel = 1'b0;
    mem_addr_sel = 1'b0; pc_src_sel = 1'b0;
    case (state_q)
      ST_FETCH: begin
        pc_we = 1'b1; ir_we = 1'b1; alu_b_sel = BSEL_FOUR;
      end
      ST_DECODE: alu_b_sel = BSEL_IMM4;
      ST_BR_CMP: begin
        alu_a_sel = 1'b1; alu_op = AOP_SUB;
        pc_src_sel = 1'b1; pc_we = alu_zero;
      end
      ST_R_EXE: begin
        alu_a_sel = 1'b1; alu_op = funct_to_aluop(funct);
      end
      ST_R_WB: begin
        rf_we = 1'b1; reg_dst_sel = 1'b1;
      end
      ST_SW_ADDR, ST_LW_ADDR: begin
        alu_a_sel = 1'b1; alu_b_sel = BSEL_IMM;
      end
      ST_SW_MEM: begin
        mem_we = 1'b1; mem_addr_sel = 1'b1;
      end
      ST_LW_MEM: mem_addr_sel = 1'b1;
      ST_LW_WB: begin
        rf_we = 1'b1; rf_wdata_sel = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  input  logic         alu_zero,
  output logic         pc_we,
  output logic         mem_we,
  output logic         rf_we,
  output logic         ir_we,
  output logic         alu_a_sel,
  output logic [1:0]   alu_b_sel,
  output logic [2:0]   alu_op,
  output logic         reg_dst_sel,
  output logic         rf_wdata_sel,
  output logic         mem_addr_sel,
  output logic         pc_src_sel
);
  instr_cls_e cls;
  seq_state_e state_q;
  logic       in_decode;
  logic       in_br_cmp;
  logic       op_known;

  assign cls       = classify(opcode);
  assign in_decode = (state_q == ST_DECODE);
  assign in_br_cmp = (state_q == ST_BR_CMP);
  assign op_known  = (cls != CLS_OTHER);

  mc_seq_next u_next (
    .clk     (clk),
    .rst_n   (rst_n),
    .cls     (cls),
    .state_q (state_q)
  );

  mc_seq_out u_out (
    .state_q      (state_q),
    .funct        (funct),
    .alu_zero     (alu_zero),
    .pc_we        (pc_we),
    .mem_we       (mem_we),
    .rf_we        (rf_we),
    .ir_we        (ir_we),
    .alu_a_sel    (alu_a_sel),
    .alu_b_sel    (alu_b_sel),
    .alu_op       (alu_op),
    .reg_dst_sel  (reg_dst_sel),
    .rf_wdata_sel (rf_wdata_sel),
    .mem_addr_sel (mem_addr_sel),
    .pc_src_sel   (pc_src_sel)
  );
endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alu_zero,
  input logic       pc_we,
  input logic       mem_we,
  input logic       rf_we,
  input logic       ir_we,
  input logic       pc_src_sel,
  input logic       in_decode,
  input logic       in_br_cmp,
  input logic       op_known
);
  // R2: fetch is followed by decode, never by another fetch
  a_r2_fetch_once: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> !ir_we);
  // R3: decode writes nothing
  a_r3_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_decode |-> !(pc_we || mem_we || rf_we || ir_we));
  // R4: branch PC write follows zero in the compare state
  a_r4_branch_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_br_cmp |-> (pc_we == alu_zero) && pc_src_sel);
  // R4: a PC write outside fetch only comes from a taken branch
  a_r4_pc_only_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !ir_we) |-> (in_br_cmp && alu_zero));
  // R6: store write ends the instruction
  a_r6_store_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ir_we);
  // R8: register write ends the instruction
  a_r8_wb_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> ir_we);
  // R9: unknown opcode returns to fetch after decode
  a_r9_unknown_back: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decode && !op_known) |=> ir_we);
  // R10: at most one of the data-side strobes
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, rf_we, ir_we}));
endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alu_zero   (alu_zero),
  .pc_we      (pc_we),
  .mem_we     (mem_we),
  .rf_we      (rf_we),
  .ir_we      (ir_we),
  .pc_src_sel (pc_src_sel),
  .in_decode  (in_decode),
  .in_br_cmp  (in_br_cmp),
  .op_known   (op_known)
);

// File: tb/mc_seq_ctrl_tb.sv
module mc_seq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic [5:0] funct = 6'd0;
  logic alu_zero = 1'b0;
  logic pc_we, mem_we, rf_we, ir_we, alu_a_sel;
  logic [1:0] alu_b_sel;
  logic [2:0] alu_op;
  logic reg_dst_sel, rf_wdata_sel, mem_addr_sel, pc_src_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .pc_we(pc_we), .mem_we(mem_we), .rf_we(rf_we), .ir_we(ir_we),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .reg_dst_sel(reg_dst_sel), .rf_wdata_sel(rf_wdata_sel),
    .mem_addr_sel(mem_addr_sel), .pc_src_sel(pc_src_sel)
  );

  // vector: {pc,mem,rf,ir, a, b[1:0], op[2:0], dst, wd, maddr, psrc}
  function automatic logic [13:0] mk(input bit pc, input bit mw, input bit rw, input bit iw,
                                     input bit a, input int b, input int op,
                                     input bit dst, input bit wd, input bit ma, input bit ps);
    return {pc, mw, rw, iw, a, 2'(b), 3'(op), dst, wd, ma, ps};
  endfunction

  function automatic logic [13:0] observed();
    return {pc_we, mem_we, rf_we, ir_we, alu_a_sel, alu_b_sel, alu_op,
            reg_dst_sel, rf_wdata_sel, mem_addr_sel, pc_src_sel};
  endfunction

  function automatic int op_of_funct(input logic [5:0] fn);
    if (fn == 6'h20) return 0;
    if (fn == 6'h22) return 1;
    if (fn == 6'h24) return 2;
    if (fn == 6'h25) return 3;
    if (fn == 6'h27) return 4;
    if (fn == 6'h2A) return 5;
    return 0;
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: builds the expected per-cycle vectors for one instruction.
  // Starts in the fetch cycle (already sampled), ends sampled in the next fetch.
  task automatic run_instr(input string req, input logic [5:0] opc, input logic [5:0] fn,
                           input bit zero, input int exp_len);
    logic [13:0] q[$];
    int k;
    q.push_back(mk(1,0,0,1, 0,1,0, 0,0,0,0));             // R2 fetch
    q.push_back(mk(0,0,0,0, 0,3,0, 0,0,0,0));             // R3 decode
    case (opc)
      6'b000100: q.push_back(mk(zero,0,0,0, 1,0,1, 0,0,0,1));       // R4
      6'b000000: begin
        q.push_back(mk(0,0,0,0, 1,0,op_of_funct(fn), 0,0,0,0));     // R5
        q.push_back(mk(0,0,1,0, 0,0,0, 1,0,0,0));
      end
      6'b101011: begin
        q.push_back(mk(0,0,0,0, 1,2,0, 0,0,0,0));                   // R6
        q.push_back(mk(0,1,0,0, 0,0,0, 0,0,1,0));
      end
      6'b100011: begin
        q.push_back(mk(0,0,0,0, 1,2,0, 0,0,0,0));                   // R7
        q.push_back(mk(0,0,0,0, 0,0,0, 0,0,1,0));
        q.push_back(mk(0,0,1,0, 0,0,0, 0,1,0,0));
      end
      default: ;                                                     // R9
    endcase
    check({req, " fetch"}, observed(), q[0]);
    k = 1;
    forever begin
      @(negedge clk);
      opcode = opc; funct = fn; alu_zero = zero;
      #1;
      if (ir_we === 1'b1 || k >= 8) break;
      if (k < q.size()) check(req, observed(), q[k]);
      else check({req, " overrun"}, observed(), q[0]);
      k++;
    end
    n_checks++;
    if (k != exp_len) begin
      n_fail++;
      $display("FAIL R8 %s: length got %0d expected %0d", req, k, exp_len);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] fns[7] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2A, 6'h3F};
    // R1: held in reset, fetch vector shown
    repeat (2) @(negedge clk);
    #1 check("R1 in reset", observed(), mk(1,0,0,1, 0,1,0, 0,0,0,0));
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 after release", observed(), mk(1,0,0,1, 0,1,0, 0,0,0,0));

    run_instr("R4 beq taken", 6'b000100, 6'h00, 1'b1, 3);
    run_instr("R4 beq not taken", 6'b000100, 6'h00, 1'b0, 3);
    foreach (fns[i]) run_instr("R5 rtype", 6'b000000, fns[i], 1'b1, 4);
    run_instr("R6 store", 6'b101011, 6'h20, 1'b1, 4);
    run_instr("R7 load", 6'b100011, 6'h22, 1'b1, 5);
    run_instr("R9 unknown", 6'b001101, 6'h20, 1'b1, 2);
    run_instr("R9 unknown jump-like", 6'b000010, 6'h00, 1'b0, 2);
    run_instr("R10 load zero low", 6'b100011, 6'h00, 1'b0, 5);

    // R1: reset in the middle of a load drops it and resumes at fetch
    @(negedge clk); opcode = 6'b100011; #1;
    check("R1 mid decode", observed(), mk(0,0,0,0, 0,3,0, 0,0,0,0));
    @(negedge clk); #1;
    check("R1 mid addr", observed(), mk(0,0,0,0, 1,2,0, 0,0,0,0));
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 async reset", observed(), mk(1,0,0,1, 0,1,0, 0,0,0,0));
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 resumed fetch", observed(), mk(1,0,0,1, 0,1,0, 0,0,0,0));
    run_instr("R8 store after reset", 6'b101011, 6'h00, 1'b0, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule